// File: doc/BRIEF.md
# JTAG Test Access Port Controller with Instruction Decode

This block is the test access port of a chip. It runs the sixteen-state test state machine on the test clock, using the mode-select input. A three-bit instruction is shifted in from the serial data input and decoded when the controller passes through Update-IR. The decoded instruction then chooses the data register that sits between serial in and serial out. The choices are a one-bit bypass stage, a 32-bit identification register held inside the block, or one of two external serial chains.

The two external chains are a boundary chain for the pins and an analog scan chain. Each chain is reached through three strobes (capture, shift and update), and each returns its serial output on a separate input. All three strobes are sampled by the chain on the rising test clock. The chains take their serial input from `tdi` directly.

A mode flag tells the pad logic whether the pins are driven from the boundary register or from the core. The serial pins have no flow control. One bit moves on every test clock in a shift state, so there is no valid/ready handshake and no back-pressure rule. Inputs are sampled on the rising edge of `tck`. `tdo` and its enable change on the falling edge.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The state machine follows the standard sixteen-state TAP graph on rising `tck`. A low `trst_n` forces Test-Logic-Reset at once. Five rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: The instruction register is set to IDCODE (110) by `trst_n`, and on every rising edge spent in Test-Logic-Reset. In that case `pin_test_mode` is low.
- R3: The instruction shift stage is three bits wide and is filled least significant bit first. Capture-IR loads 001 into it, so the first three `tdo` bits of any IR scan are 1, 0, 0.
- R4: The active instruction, and with it `pin_test_mode`, changes only on the edge that leaves Update-IR or on a reset. It holds through Shift-IR, Exit1-IR and Update-IR.
- R5: IDCODE (110) places a 32-bit register on the path. Capture-DR loads `ID_VALUE` into it, whose bit 0 is 1, and the register shifts out least significant bit first.
- R6: BYPASS (111) places a single stage on the path. That stage captures 0, so `tdo` gives a 0 followed by `tdi` delayed by one cycle.
- R7: The undefined codes 001, 011 and 101 act exactly as BYPASS and leave `pin_test_mode` low.
- R8: EXTEST (000) selects the boundary chain, so `tdo` follows `bsc_so`, and it drives `pin_test_mode` high.
- R9: SAMPLE/PRELOAD (100) selects the boundary chain, with `pin_test_mode` low.
- R10: Code 010 selects the analog chain, so `tdo` follows `asc_so`. The boundary strobes stay idle.
- R11: `tdo` and `tdo_oe` are registered on falling `tck`. `tdo_oe` is high only after a falling edge in Shift-DR or Shift-IR.
- R12: The strobes of the selected chain are driven as follows: capture is high in Capture-DR, shift is high in Shift-DR and update is high in Update-DR. The strobes of any chain that is not selected stay low, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| pin_test_mode | output | 1 | High: pins are driven from the boundary register |
| bsc_capture | output | 1 | Boundary chain capture strobe |
| bsc_shift | output | 1 | Boundary chain shift strobe |
| bsc_update | output | 1 | Boundary chain update strobe |
| bsc_so | input | 1 | Serial return from the boundary chain |
| asc_capture | output | 1 | Analog chain capture strobe |
| asc_shift | output | 1 | Analog chain shift strobe |
| asc_update | output | 1 | Analog chain update strobe |
| asc_so | input | 1 | Serial return from the analog chain |

## Verification
The bench builds the block with `ID_VALUE` = 32'h2B6D4C17, not the default. The scan then shows that the ordering of the full 32-bit identification word is taken from the parameter, and that bit 0 is shifted out first. The width stays at 32 so that each IDCODE scan can be compared with the word bit by bit. Small 4-bit boundary and analog chains in the bench make capture, shifting in both directions and the update result visible at the ports for EXTEST, SAMPLE/PRELOAD and the analog code.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP, PATH_ID, PATH_BSC, PATH_ASC
  } dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_ANALOG  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b110;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic dr_path_e decode_path(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: decode_path = PATH_BSC;
      OP_ANALOG:            decode_path = PATH_ASC;
      OP_IDCODE:            decode_path = PATH_ID;
      default:              decode_path = PATH_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end

  // Run of consecutive high tms samples, saturating at five; checking aid
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           tms_run <= '0;
    else if (!tms)         tms_run <= '0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  // R1
  tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic            ir_lsb,
  output dr_path_e        path,
  output logic            pin_test_mode
);

  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_act;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh  <= IR_CAPTURE;
      ir_act <= OP_IDCODE;
    end else begin
      if (state == ST_CAP_IR)     ir_sh <= IR_CAPTURE;
      else if (state == ST_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};

      if (state == ST_RESET)       ir_act <= OP_IDCODE;
      else if (state == ST_UPD_IR) ir_act <= ir_sh;
    end
  end

  assign ir_lsb        = ir_sh[0];
  assign path          = decode_path(ir_act);
  assign pin_test_mode = (ir_act == OP_EXTEST);

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_lsb == 1'b1));

  // R4
  instr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(state == ST_UPD_IR || state == ST_RESET) |=> $stable(ir_act));

  // R8
  mode_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(pin_test_mode) |-> ($past(state) == ST_UPD_IR));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_30E3
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  dr_path_e   path,
  input  logic       bsc_so,
  input  logic       asc_so,
  output logic       bsc_capture,
  output logic       bsc_shift,
  output logic       bsc_update,
  output logic       asc_capture,
  output logic       asc_shift,
  output logic       asc_update,
  output logic       dr_bit
);

  localparam int N_CHAIN = 2;

  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic [N_CHAIN-1:0] cap_v, sh_v, upd_v;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else begin
      if (state == ST_CAP_DR && path == PATH_BYP)     byp_q <= 1'b0;
      else if (state == ST_SH_DR && path == PATH_BYP) byp_q <= tdi;

      if (state == ST_CAP_DR && path == PATH_ID)      id_q <= ID_VALUE;
      else if (state == ST_SH_DR && path == PATH_ID)  id_q <= {tdi, id_q[ID_W-1:1]};
    end
  end

  // Strobes for the external chains: index 0 boundary, index 1 analog
  for (genvar g = 0; g < N_CHAIN; g++) begin : g_chain
    localparam dr_path_e MY_PATH = (g == 0) ? PATH_BSC : PATH_ASC;
    assign cap_v[g] = (path == MY_PATH) && (state == ST_CAP_DR);
    assign sh_v[g]  = (path == MY_PATH) && (state == ST_SH_DR);
    assign upd_v[g] = (path == MY_PATH) && (state == ST_UPD_DR);
  end

  assign bsc_capture = cap_v[0];
  assign bsc_shift   = sh_v[0];
  assign bsc_update  = upd_v[0];
  assign asc_capture = cap_v[1];
  assign asc_shift   = sh_v[1];
  assign asc_update  = upd_v[1];

  always_comb begin
    case (path)
      PATH_ID:  dr_bit = id_q[0];
      PATH_BSC: dr_bit = bsc_so;
      PATH_ASC: dr_bit = asc_so;
      default:  dr_bit = byp_q;
    endcase
  end

  // R12
  strobe_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({cap_v, sh_v, upd_v}));

  // R6
  byp_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && path == PATH_BYP) |=> (byp_q == 1'b0));

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_30E3
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  output logic pin_test_mode,
  output logic bsc_capture,
  output logic bsc_shift,
  output logic bsc_update,
  input  logic bsc_so,
  output logic asc_capture,
  output logic asc_shift,
  output logic asc_update,
  input  logic asc_so
);

  tap_state_e state;
  dr_path_e   path;
  logic       ir_lsb;
  logic       dr_bit;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .ir_lsb(ir_lsb), .path(path), .pin_test_mode(pin_test_mode)
  );

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .path(path),
    .bsc_so(bsc_so), .asc_so(asc_so),
    .bsc_capture(bsc_capture), .bsc_shift(bsc_shift), .bsc_update(bsc_update),
    .asc_capture(asc_capture), .asc_shift(asc_shift), .asc_update(asc_update),
    .dr_bit(dr_bit)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SH_DR) || (state == ST_SH_IR);
      tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_bit;
    end
  end

  // R11
  oe_shift_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

// File: tb/jtag_tap_ctrl_bench.sv
module jtag_tap_ctrl_bench;

  localparam int          TCK_NS  = 200;
  localparam logic [31:0] BENCH_ID = 32'h2B6D_4C17;
  localparam logic [3:0]  BSC_PINS = 4'b1011;
  localparam logic [3:0]  ASC_PINS = 4'b0110;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, pin_test_mode;
  logic bsc_capture, bsc_shift, bsc_update, bsc_so;
  logic asc_capture, asc_shift, asc_update, asc_so;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #(TCK_NS/2) tck = ~tck;

  jtag_tap_ctrl #(.ID_W(32), .ID_VALUE(BENCH_ID)) u_jtag_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_test_mode(pin_test_mode),
    .bsc_capture(bsc_capture), .bsc_shift(bsc_shift), .bsc_update(bsc_update),
    .bsc_so(bsc_so),
    .asc_capture(asc_capture), .asc_shift(asc_shift), .asc_update(asc_update),
    .asc_so(asc_so)
  );

  // Small external chains standing in for the boundary and analog registers
  logic [3:0] bsc_ch = '0, bsc_out = '0, asc_ch = '0, asc_out = '0;
  always @(posedge tck) begin
    if (bsc_capture)     bsc_ch <= BSC_PINS;
    else if (bsc_shift)  bsc_ch <= {tdi, bsc_ch[3:1]};
    if (bsc_update)      bsc_out <= bsc_ch;
    if (asc_capture)     asc_ch <= ASC_PINS;
    else if (asc_shift)  asc_ch <= {tdi, asc_ch[3:1]};
    if (asc_update)      asc_out <= asc_ch;
  end
  assign bsc_so = bsc_ch[0];
  assign asc_so = asc_ch[0];

  int n_bcap, n_bupd, n_bsh, n_acap, n_aupd, n_ash;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: strobe counts and TDO scoreboard, sampled after the falling edge
  always @(negedge tck) begin
    #(TCK_NS/10);
    if (bsc_capture) n_bcap++;
    if (bsc_shift)   n_bsh++;
    if (bsc_update)  n_bupd++;
    if (asc_capture) n_acap++;
    if (asc_shift)   n_ash++;
    if (asc_update)  n_aupd++;
    if (tdo_oe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 actual=tdo_oe high expected=no scan in progress");
      end else begin
        bit e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {31'd0, tdo}, {31'd0, e});
      end
    end
  end

  task automatic clr_counts();
    n_bcap = 0; n_bupd = 0; n_bsh = 0; n_acap = 0; n_aupd = 0; n_ash = 0;
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #(TCK_NS/4);
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic scan_ir(input logic [2:0] op, input logic old_mode,
                         input logic new_mode, input string req);
    exp_q.push_back(1'b1); tag_q.push_back("R3");
    exp_q.push_back(1'b0); tag_q.push_back("R3");
    exp_q.push_back(1'b0); tag_q.push_back("R3");
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, op[i]);
    check("R4 mode held in Exit1-IR", {31'd0, pin_test_mode}, {31'd0, old_mode});
    step(1, 0);
    check("R4 mode held in Update-IR", {31'd0, pin_test_mode}, {31'd0, old_mode});
    step(0, 0);
    check(req, {31'd0, pin_test_mode}, {31'd0, new_mode});
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din,
                         input logic [31:0] dexp, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(dexp[i]); tag_q.push_back(req);
    end
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [31:0] byp_expect(input int n, input logic [31:0] din);
    logic [31:0] r = '0;
    for (int i = 1; i < n; i++) r[i] = din[i-1];
    return r;
  endfunction

  initial begin
    #(TCK_NS * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_counts();
    #(TCK_NS * 2 + 30);
    check("R2 mode after reset", {31'd0, pin_test_mode}, 32'd0);
    check("R11 oe after reset", {31'd0, tdo_oe}, 32'd0);
    check("R12 strobes idle in reset",
          {26'd0, bsc_capture, bsc_shift, bsc_update, asc_capture, asc_shift, asc_update}, 32'd0);
    trst_n = 1'b1;
    step(1, 0);
    step(0, 0);

    // R5: IDCODE is active after reset
    scan_dr(32, 32'hFFFF_0000, BENCH_ID, "R5");
    check("R5 id bit0 is one", {31'd0, BENCH_ID[0]}, 32'd1);
    scan_dr(32, 32'h0, BENCH_ID, "R5 recapture");
    check("R11 oe low in idle", {31'd0, tdo_oe}, 32'd0);

    // R6: BYPASS
    scan_ir(3'b111, 1'b0, 1'b0, "R6 mode");
    scan_dr(8, 32'h0000_00B5, byp_expect(8, 32'h0000_00B5), "R6");

    // R7: undefined codes behave as bypass
    scan_ir(3'b001, 1'b0, 1'b0, "R7 mode 001");
    scan_dr(6, 32'h0000_0027, byp_expect(6, 32'h0000_0027), "R7 code 001");
    scan_ir(3'b011, 1'b0, 1'b0, "R7 mode 011");
    scan_dr(5, 32'h0000_001A, byp_expect(5, 32'h0000_001A), "R7 code 011");
    scan_ir(3'b101, 1'b0, 1'b0, "R7 mode 101");
    clr_counts();
    scan_dr(5, 32'h0000_000D, byp_expect(5, 32'h0000_000D), "R7 code 101");
    check("R7 boundary idle", n_bcap + n_bsh + n_bupd, 32'd0);

    // R8: EXTEST
    scan_ir(3'b000, 1'b0, 1'b1, "R8 mode high");
    clr_counts();
    scan_dr(4, 32'h5, {28'd0, BSC_PINS}, "R8");
    check("R12 boundary capture count", n_bcap, 32'd1);
    check("R12 boundary shift count", n_bsh, 32'd4);
    check("R12 boundary update count", n_bupd, 32'd1);
    check("R12 boundary updated value", {28'd0, bsc_out}, 32'h5);
    check("R12 analog idle under EXTEST", n_acap + n_ash + n_aupd, 32'd0);

    // R9: SAMPLE/PRELOAD
    scan_ir(3'b100, 1'b1, 1'b0, "R9 mode low");
    clr_counts();
    scan_dr(4, 32'hA, {28'd0, BSC_PINS}, "R9");
    check("R9 boundary updated value", {28'd0, bsc_out}, 32'hA);
    check("R9 boundary capture count", n_bcap, 32'd1);

    // R10: analog chain
    scan_ir(3'b010, 1'b0, 1'b0, "R10 mode");
    clr_counts();
    scan_dr(4, 32'h9, {28'd0, ASC_PINS}, "R10");
    check("R10 analog updated value", {28'd0, asc_out}, 32'h9);
    check("R10 analog capture count", n_acap, 32'd1);
    check("R10 boundary idle", n_bcap + n_bsh + n_bupd, 32'd0);

    // R1 and R2: five TMS-high cycles restore IDCODE
    scan_ir(3'b000, 1'b0, 1'b1, "R8 mode high again");
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    check("R1 tms reset clears mode", {31'd0, pin_test_mode}, 32'd0);
    scan_dr(32, 32'h0, BENCH_ID, "R1 idcode after tms reset");

    // R1 and R2: asynchronous reset
    scan_ir(3'b000, 1'b0, 1'b1, "R8 mode before trst");
    @(negedge tck);
    #(TCK_NS/4);
    trst_n = 1'b0;
    #5;
    check("R1 trst clears mode at once", {31'd0, pin_test_mode}, 32'd0);
    check("R11 trst clears oe", {31'd0, tdo_oe}, 32'd0);
    #(TCK_NS);
    trst_n = 1'b1;
    step(0, 0);
    scan_dr(32, 32'h0, BENCH_ID, "R2 idcode after trst");

    step(0, 0); step(0, 0);
    check("R11 scoreboard drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule